// File: doc/BRIEF.md
# Dual-Slot Receive Frame Buffer

This block takes an incoming Ethernet frame as a byte stream and stores it in one of two receive slots of 2048 bytes each. Software owns a 2-bit state per slot. It arms a slot by writing "loaded". The block then fills the lowest armed slot with a complete frame image and marks that slot "pending". The image holds a regenerated preamble and start delimiter, the payload, zero padding up to the Ethernet minimum, and a CRC-32 check sequence.

When a frame arrives and no slot is armed, the stream is held off (`in_ready` stays low) until software arms one. A frame too large for a slot is consumed and discarded. A level interrupt reports that at least one slot holds an unread frame. Software reads the stored bytes through a synchronous read port.

Top module: `rx_slot_buffer`

## Requirements
- R1: After reset both slot states and both counts are 0, `rx_irq` is low and `in_ready` is low. State codes: 0 = empty, 1 = loaded (armed), 2 = pending (holds a frame). A write with `st_we[i]` high sets the state of slot i to `st_wdata` at the next clock edge.
- R2: A new frame goes to slot 0 if its state is 1, otherwise to slot 1 if its state is 1. If neither slot is 1, `in_ready` stays low and the frame waits upstream.
- R3: In the chosen slot, offsets 0 to 6 hold 0x55, offset 7 holds 0xD5, and payload byte k is stored at offset 8+k.
- R4: A payload of L < 60 bytes is followed by 60-L zero bytes, which are included in the check sequence.
- R5: The check sequence is CRC-32 (reflected polynomial 0xEDB88320, initial value all ones, final inversion) over the padded payload. It is stored least significant byte first at offset 8+P, where P = max(L,60).
- R6: A frame whose payload exceeds 2036 bytes is accepted to its last byte and then dropped, and the count and state of both slots stay unchanged.
- R7: When a frame is stored, the slot count becomes P+12 and the slot state becomes 2. The update happens 4 clock edges after the last byte is accepted, plus one edge per pad byte.
- R8: `rx_irq` is high exactly while either slot state is 2. It follows both software state writes and frame completion.
- R9: `rd_data` shows the byte at offset `rd_off` of slot `rd_slot` one clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Block accepts the stream byte |
| st_we | input | 2 | Per-slot state write enable |
| st_wdata | input | 2 | State value to write |
| st0 | output | 2 | Slot 0 state |
| st1 | output | 2 | Slot 1 state |
| cnt0 | output | 12 | Slot 0 byte count |
| cnt1 | output | 12 | Slot 1 byte count |
| rx_irq | output | 1 | Receive interrupt level |
| rd_slot | input | 1 | Read slot select |
| rd_off | input | 11 | Read byte offset |
| rd_data | output | 8 | Read byte, one cycle latency |

## Verification
The assertions assume that software never writes the state of the slot being filled while a frame is in progress. Under that assumption, a slot reaches pending only from loaded and always with an in-range count. They also assume that the upstream source holds `in_valid` and its byte until accepted. The stimulus arms slots only between frames and drives every byte until `in_ready` is seen. Under these conditions the commit cycle can be predicted from the frame length, and the reference model compares states, counts and the interrupt on every clock.

// File: rtl/rx_slot_buffer.sv
module rx_slot_buffer #(
  parameter int SLOT_BYTES  = 2048,
  parameter int MIN_PAYLOAD = 60,
  localparam int AW = $clog2(SLOT_BYTES),
  localparam int CW = $clog2(SLOT_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          in_ready,
  input  logic [1:0]    st_we,
  input  logic [1:0]    st_wdata,
  output logic [1:0]    st0,
  output logic [1:0]    st1,
  output logic [CW-1:0] cnt0,
  output logic [CW-1:0] cnt1,
  output logic          rx_irq,
  input  logic          rd_slot,
  input  logic [AW-1:0] rd_off,
  output logic [7:0]    rd_data
);
  // SLOT_BYTES must be a power of two: slot index forms the top address bit.
  localparam int MAXPAY = SLOT_BYTES - 12;

  typedef enum logic [2:0] {P_IDLE, P_PRE, P_DATA, P_PAD, P_FCS} phase_t;

  phase_t        phase;
  logic          slot;
  logic [2:0]    ph;
  logic [CW-1:0] n;
  logic          ovf;
  logic [31:0]   crc;
  logic [1:0]    st  [2];
  logic [CW-1:0] cnt [2];
  logic [7:0]    mem [2*SLOT_BYTES];

  logic          wr_en;
  logic [AW-1:0] wr_off;
  logic [7:0]    wr_byte;
  logic [31:0]   fcs;
  logic          accept, take, over, commit;
  logic [CW-1:0] n_inc;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int k = 0; k < 8; k++)
      r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  assign in_ready = (phase == P_DATA);
  assign accept   = in_valid && in_ready;
  assign take     = accept && !ovf && (n < CW'(MAXPAY));
  assign over     = accept && !take;
  assign n_inc    = n + CW'(1);
  assign fcs      = ~crc;
  assign commit   = (phase == P_FCS) && (ph == 3'd3);
  assign st0      = st[0];
  assign st1      = st[1];
  assign cnt0     = cnt[0];
  assign cnt1     = cnt[1];
  assign rx_irq   = (st[0] == 2'd2) || (st[1] == 2'd2);

  always_comb begin
    wr_en   = 1'b0;
    wr_off  = AW'(n) + AW'(8);
    wr_byte = 8'h00;
    case (phase)
      P_PRE: begin
        wr_en   = 1'b1;
        wr_off  = AW'(ph);
        wr_byte = (ph == 3'd7) ? 8'hD5 : 8'h55;
      end
      P_DATA: begin
        wr_en   = take;
        wr_byte = in_data;
      end
      P_PAD: wr_en = 1'b1;
      P_FCS: begin
        wr_en   = 1'b1;
        wr_off  = AW'(n) + AW'(8) + AW'(ph);
        wr_byte = fcs[8*ph[1:0] +: 8];
      end
      default: wr_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_IDLE;
      slot  <= 1'b0;
      ph    <= '0;
      n     <= '0;
      ovf   <= 1'b0;
      crc   <= '1;
    end else begin
      case (phase)
        P_IDLE:
          if (in_valid && (st[0] == 2'd1 || st[1] == 2'd1)) begin
            slot  <= (st[0] != 2'd1);
            phase <= P_PRE;
            ph    <= '0;
            n     <= '0;
            ovf   <= 1'b0;
            crc   <= '1;
          end
        P_PRE: begin
          ph <= ph + 3'd1;
          if (ph == 3'd7) phase <= P_DATA;
        end
        P_DATA: begin
          if (take) begin
            crc <= crc_step(crc, in_data);
            n   <= n_inc;
          end
          if (over) ovf <= 1'b1;
          if (accept && in_last) begin
            if (ovf || over)                   phase <= P_IDLE;
            else if (n_inc < CW'(MIN_PAYLOAD)) phase <= P_PAD;
            else                               phase <= P_FCS;
          end
        end
        P_PAD: begin
          crc <= crc_step(crc, 8'h00);
          n   <= n_inc;
          if (n_inc == CW'(MIN_PAYLOAD)) phase <= P_FCS;
        end
        P_FCS: begin
          ph <= ph + 3'd1;
          if (ph == 3'd3) phase <= P_IDLE;
        end
        default: phase <= P_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st[i]  <= 2'd0;
        cnt[i] <= '0;
      end else if (commit && slot == 1'(i)) begin
        st[i]  <= 2'd2;
        cnt[i] <= n + CW'(12);
      end else if (st_we[i]) begin
        st[i]  <= st_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[{slot, wr_off}] <= wr_byte;
    rd_data <= mem[{rd_slot, rd_off}];
  end

  // R2
  pend_from_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_we[0] && st[0] != 2'd2) |=> (st[0] != 2'd2 || $past(st[0]) == 2'd1));

  // R7
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_we[1] && st[1] != 2'd2) |=> (st[1] != 2'd2 || (cnt[1] >= CW'(72) && cnt[1] <= CW'(SLOT_BYTES))));

  // R8
  irq_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(st[0]) && $stable(st[1])) |-> $stable(rx_irq));

  // R2
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready);
endmodule

// File: tb/sim_rx_slot_buffer.sv
module sim_rx_slot_buffer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready;
  logic [1:0] st_we = 2'b00, st_wdata = 2'b00;
  logic [1:0] st0, st1;
  logic [11:0] cnt0, cnt1;
  logic rx_irq;
  logic rd_slot = 1'b0;
  logic [10:0] rd_off = '0;
  logic [7:0] rd_data;

  always #2.5 clk = ~clk;

  rx_slot_buffer u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .st_we(st_we), .st_wdata(st_wdata),
    .st0(st0), .st1(st1), .cnt0(cnt0), .cnt1(cnt1), .rx_irq(rx_irq),
    .rd_slot(rd_slot), .rd_off(rd_off), .rd_data(rd_data));

  int checks = 0, failures = 0, cyc = 0;
  int mst[2], mcnt[2];
  bit commit_pend = 0; int commit_cyc, cs, cv;
  bit wr_pend = 0; int ws, wv;
  logic [7:0] img[$];

  function automatic logic [7:0] pbyte(int seed, int i);
    return 8'((seed * 31 + i * 13) ^ (i >> 4));
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (commit_pend && cyc == commit_cyc) begin
      mst[cs] = 2; mcnt[cs] = cv; commit_pend = 0;
    end
    if (wr_pend) begin mst[ws] = wv; wr_pend = 0; end
    if (rst_n) begin
      chk(int'(st0) == mst[0], "R7", "slot0 state", st0, mst[0]);
      chk(int'(st1) == mst[1], "R7", "slot1 state", st1, mst[1]);
      chk(int'(cnt0) == mcnt[0], "R7", "slot0 count", cnt0, mcnt[0]);
      chk(int'(cnt1) == mcnt[1], "R7", "slot1 count", cnt1, mcnt[1]);
      chk(rx_irq == (mst[0] == 2 || mst[1] == 2), "R8", "irq level", rx_irq,
          int'(mst[0] == 2 || mst[1] == 2));
    end
  endtask

  task automatic sw_write(int s, int v);
    st_we[s] = 1'b1; st_wdata = 2'(v);
    ws = s; wv = v; wr_pend = 1;
    tick();
    st_we = 2'b00;
  endtask

  task automatic send_frame(int len, int seed);
    int sl, acc, guard;
    sl = (mst[0] == 1) ? 0 : ((mst[1] == 1) ? 1 : -1);
    acc = 0;
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1; in_data = pbyte(seed, i); in_last = (i == len - 1);
      guard = 0;
      while (!in_ready && guard < 5000) begin tick(); guard++; end
      acc = cyc + 1;
      tick();
    end
    in_valid = 1'b0; in_last = 1'b0;
    if (len <= 2036 && sl >= 0) begin
      commit_pend = 1; cs = sl;
      commit_cyc = acc + ((len < 60) ? 60 - len : 0) + 4;
      cv = ((len < 60) ? 60 : len) + 12;
    end
    repeat (70) tick();
  endtask

  task automatic check_image(int s, int len, int seed);
    int p, bad_pre, bad_pay, bad_pad, bad_fcs, fb, fe;
    logic [31:0] c;
    p = (len < 60) ? 60 : len;
    img.delete();
    for (int i = 0; i < 7; i++) img.push_back(8'h55);
    img.push_back(8'hD5);
    for (int i = 0; i < p; i++) img.push_back(i < len ? pbyte(seed, i) : 8'h00);
    c = 32'hFFFFFFFF;
    for (int i = 8; i < 8 + p; i++) begin
      c = c ^ {24'd0, img[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    c = ~c;
    for (int k = 0; k < 4; k++) img.push_back(c[8*k +: 8]);
    bad_pre = 0; bad_pay = 0; bad_pad = 0; bad_fcs = 0; fb = 0; fe = 0;
    rd_slot = 1'(s);
    for (int i = 0; i < p + 12; i++) begin
      rd_off = 11'(i);
      tick();
      if (rd_data !== img[i]) begin
        if (bad_pre + bad_pay + bad_pad + bad_fcs == 0) begin fb = rd_data; fe = img[i]; end
        if (i < 8) bad_pre++;
        else if (i < 8 + len) bad_pay++;
        else if (i < 8 + p) bad_pad++;
        else bad_fcs++;
      end
    end
    chk(bad_pre == 0, "R3", "preamble byte", fb, fe);
    chk(bad_pay == 0, "R3", "payload byte (R9 read)", fb, fe);
    chk(bad_pad == 0, "R4", "pad byte", fb, fe);
    chk(bad_fcs == 0, "R5", "fcs byte", fb, fe);
  endtask

  initial begin
    mst[0] = 0; mst[1] = 0; mcnt[0] = 0; mcnt[1] = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(st0 == 2'd0 && st1 == 2'd0, "R1", "reset states", {st0, st1}, 0);
    chk(cnt0 == 0 && cnt1 == 0 && !rx_irq && !in_ready, "R1", "reset count/irq/ready",
        {cnt0, rx_irq, in_ready}, 0);

    // R2 nothing armed: stream held off
    in_valid = 1'b1; in_data = 8'hAA;
    for (int i = 0; i < 20; i++) begin
      tick();
      chk(!in_ready, "R2", "ready with no slot armed", in_ready, 0);
    end
    in_valid = 1'b0;

    // R2 only slot 1 armed
    sw_write(1, 1);
    send_frame(64, 1);
    check_image(1, 64, 1);
    // R2 slot 0 taken when slot 1 is pending
    sw_write(0, 1);
    send_frame(10, 2);
    check_image(0, 10, 2);
    // R8 clearing states lowers irq only when both cleared
    sw_write(1, 0);
    sw_write(0, 0);
    // R2 priority with both armed, back-to-back frames
    sw_write(0, 1);
    sw_write(1, 1);
    send_frame(59, 3);
    send_frame(60, 4);
    check_image(0, 59, 3);
    check_image(1, 60, 4);
    // R6 oversize dropped, then largest legal frame
    sw_write(0, 1);
    sw_write(1, 1);
    send_frame(2037, 5);
    chk(st0 == 2'd1 && st1 == 2'd1, "R6", "states after oversize", {st0, st1}, 5);
    chk(cnt0 == 12'd72 && cnt1 == 12'd72, "R6", "counts after oversize", cnt0, 72);
    send_frame(2036, 6);
    chk(cnt0 == 12'd2048, "R7", "max frame count", cnt0, 2048);
    check_image(0, 2036, 6);
    send_frame(1, 7);
    check_image(1, 1, 7);
    chk(rx_irq, "R8", "irq with pending slots", rx_irq, 1);
    // R1 software write of arbitrary code
    sw_write(0, 3);
    chk(st0 == 2'd3, "R1", "state write", st0, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog: cycles=%0d expected completion", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule